// File: doc/BRIEF.md
# External Bus Cycle Wait Controller

This block runs one read or write cycle on an external bus for a microcontroller-style bus master. A request arrives with a small set of command fields: direction, bus mode (multiplexed or demultiplexed), a programmed waitstate count, a trailing tristate waitstate enable, a READY-control enable and the choice between synchronous and asynchronous READY. While the cycle runs, the controller holds the matching active-low read or write strobe. It lets the programmed waitstates elapse. After that, if READY control is on, it keeps the strobe active for as long as the active-low READY input reads inactive.

Two READY paths are provided. The synchronous path uses the value registered once from the pin. The asynchronous path adds a second flop for metastability and so costs at least one more waitstate. After the strobe ends, the block pulses `done_o` for one cycle. It then stays busy for a trailing delay: one intrinsic cycle in multiplexed mode plus one optional tristate cycle. Only after that does it accept the next request.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, `rd_no` and `wr_no` are high, `done_o` is low and `busy_o` is low, and they stay that way while no request is made.
- R2: A request (`req_i` high while `busy_o` is low) is accepted on the clock edge. In the next cycle the strobe selected by `wr_i` (0 = `rd_no`, 1 = `wr_no`) goes low. The other strobe never goes low in the same cycle.
- R3: With READY control disabled, the strobe lasts exactly `ws_i`+1 cycles, whatever READY does. A `ws_i` of 0 is legal and gives a one-cycle strobe.
- R4: With synchronous READY, strobe cycles are numbered from 0. If `ready_ni` first goes low during strobe cycle d and stays low, the strobe lasts max(`ws_i`, d+1)+1 cycles.
- R5: With asynchronous READY, under the same stimulus as R4, the strobe lasts max(`ws_i`, d+2)+1 cycles.
- R6: `done_o` is high for exactly one cycle, namely the first cycle after the last strobe cycle. It is never high while a strobe is active.
- R7: After the strobe ends, `busy_o` stays high for T = `mux_i` + `trail_ws_i` cycles, counted from the `done_o` cycle. With `req_i` held high, the next strobe begins T+1 cycles after the last strobe cycle.
- R8: All command fields are captured when a request is accepted. Changing `wr_i`, `ws_i`, `mux_i`, `trail_ws_i`, `rdy_en_i` or `rdy_async_i` during a running cycle has no effect on that cycle. A request made while `busy_o` is high is not taken until `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| mux_i | input | 1 | 1 = multiplexed bus mode (one trailing intrinsic cycle) |
| ws_i | input | WS_W | Programmed waitstate count |
| trail_ws_i | input | 1 | Enables the trailing tristate waitstate |
| rdy_en_i | input | 1 | Enables READY-controlled cycle extension |
| rdy_async_i | input | 1 | 1 = asynchronous READY path, 0 = synchronous |
| ready_ni | input | 1 | External READY, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-cycle pulse when the strobe has ended |
| busy_o | output | 1 | High from acceptance until the trailing delay ends |

## Verification
Two events can land on the same clock edge: the last programmed waitstate running out and the first READY sample that reads active. The sweep provokes this by moving the cycle at which READY falls across every programmed count. That includes the case d+1 = `ws_i` on the synchronous path and d+2 = `ws_i` on the asynchronous one. In the coincident case the expected strobe length is computed as the larger of the two limits, with no extra cycle allowed. A second pair can also coincide when there is no trailing delay: the `done_o` pulse and acceptance of a held request. A back-to-back run checks that the next strobe opens exactly one cycle after the previous one ended.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_TRAIL  = 2'd2
  } bwc_state_e;

  typedef struct packed {
    logic wr;
    logic mux;
    logic trail_ws;
    logic rdy_en;
    logic rdy_async;
  } bwc_cfg_t;

  localparam int unsigned TR_W = 2;

endpackage

// File: rtl/bwc_rdy_sync.sv
`timescale 1ns/1ps
// READY capture chain; stage 0 feeds the synchronous path, last stage the asynchronous one
module bwc_rdy_sync #(
  parameter int unsigned ASYNC_FF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_ni,
  input  logic async_i,
  output logic rdy_seen_o
);
  localparam int unsigned LAST = ASYNC_FF - 1;

  logic [ASYNC_FF-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b1;
    else         stage_q[0] <= ready_ni;
  end

  for (genvar g = 1; g < ASYNC_FF; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b1;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign rdy_seen_o = async_i ? !stage_q[LAST] : !stage_q[0];

endmodule

// File: rtl/bwc_down_cnt.sv
`timescale 1ns/1ps
module bwc_down_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bwc_seq.sv
`timescale 1ns/1ps
module bwc_seq
  import bwc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            ws_zero_i,
  input  logic            tr_zero_i,
  input  logic            rdy_en_i,
  input  logic            rdy_seen_i,
  input  logic [TR_W-1:0] trail_len_i,
  output logic            accept_o,
  output logic            ws_dec_o,
  output logic            tr_load_o,
  output logic [TR_W-1:0] tr_val_o,
  output logic            tr_dec_o,
  output bwc_state_e      state_o,
  output logic            done_o
);
  bwc_state_e state_q, state_d;
  logic       end_c;
  logic       done_q;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    end_c    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_STROBE;
        end
      end
      ST_STROBE: begin
        // READY is only consulted once programmed waitstates are spent
        if (ws_zero_i && (!rdy_en_i || rdy_seen_i)) begin
          end_c   = 1'b1;
          state_d = (trail_len_i != '0) ? ST_TRAIL : ST_IDLE;
        end
      end
      ST_TRAIL: begin
        if (tr_zero_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= end_c;
    end
  end

  assign ws_dec_o  = (state_q == ST_STROBE) && !ws_zero_i;
  assign tr_load_o = end_c;
  assign tr_val_o  = trail_len_i - 1'b1;
  assign tr_dec_o  = (state_q == ST_TRAIL) && !tr_zero_i;
  assign state_o   = state_q;
  assign done_o    = done_q;

endmodule

// File: rtl/bus_wait_ctrl.sv
`timescale 1ns/1ps
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int unsigned WS_W     = 4,
  parameter int unsigned ASYNC_FF = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            wr_i,
  input  logic            mux_i,
  input  logic [WS_W-1:0] ws_i,
  input  logic            trail_ws_i,
  input  logic            rdy_en_i,
  input  logic            rdy_async_i,
  input  logic            ready_ni,
  output logic            rd_no,
  output logic            wr_no,
  output logic            done_o,
  output logic            busy_o
);
  bwc_cfg_t        cfg_q;
  bwc_state_e      state;
  logic            accept;
  logic            ws_zero, ws_dec;
  logic            tr_zero, tr_dec, tr_load;
  logic [TR_W-1:0] tr_val, trail_len;
  logic            rdy_seen;
  logic            strobe_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= '{wr: wr_i, mux: mux_i, trail_ws: trail_ws_i,
                 rdy_en: rdy_en_i, rdy_async: rdy_async_i};
    end
  end

  assign trail_len = {1'b0, cfg_q.mux} + {1'b0, cfg_q.trail_ws};

  bwc_rdy_sync #(.ASYNC_FF(ASYNC_FF)) u_rdy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_ni   (ready_ni),
    .async_i    (cfg_q.rdy_async),
    .rdy_seen_o (rdy_seen)
  );

  bwc_down_cnt #(.W(WS_W)) u_ws_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (ws_i),
    .dec_i  (ws_dec),
    .zero_o (ws_zero)
  );

  bwc_down_cnt #(.W(TR_W)) u_tr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tr_load),
    .val_i  (tr_val),
    .dec_i  (tr_dec),
    .zero_o (tr_zero)
  );

  bwc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .ws_zero_i   (ws_zero),
    .tr_zero_i   (tr_zero),
    .rdy_en_i    (cfg_q.rdy_en),
    .rdy_seen_i  (rdy_seen),
    .trail_len_i (trail_len),
    .accept_o    (accept),
    .ws_dec_o    (ws_dec),
    .tr_load_o   (tr_load),
    .tr_val_o    (tr_val),
    .tr_dec_o    (tr_dec),
    .state_o     (state),
    .done_o      (done_o)
  );

  assign strobe_act = (state == ST_STROBE);
  assign rd_no      = !(strobe_act && !cfg_q.wr);
  assign wr_no      = !(strobe_act &&  cfg_q.wr);
  assign busy_o     = (state != ST_IDLE);

endmodule

// File: rtl/bus_wait_ctrl_chk.sv
`timescale 1ns/1ps
module bus_wait_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic rd_no,
  input logic wr_no,
  input logic done_o,
  input logic busy_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_no && wr_no && !done_o) || done_o && rd_no && wr_no);

  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (!rd_no || !wr_no));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && $past(!rd_no || !wr_no)));

  assert_dir_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || !rd_no) |=> !(($past(!wr_no) && !rd_no) || ($past(!rd_no) && !wr_no)));

endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .rd_no  (rd_no),
  .wr_no  (wr_no),
  .done_o (done_o),
  .busy_o (busy_o)
);

// File: tb/sim_bus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_bus_wait_ctrl;
  localparam int WS_W = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0, wr_i = 1'b0, mux_i = 1'b0, trail_ws_i = 1'b0;
  logic            rdy_en_i = 1'b0, rdy_async_i = 1'b0, ready_ni = 1'b1;
  logic [WS_W-1:0] ws_i = '0;
  logic            rd_no, wr_no, done_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_wait_ctrl #(.WS_W(WS_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .mux_i(mux_i),
    .ws_i(ws_i), .trail_ws_i(trail_ws_i), .rdy_en_i(rdy_en_i),
    .rdy_async_i(rdy_async_i), .ready_ni(ready_ni), .rd_no(rd_no),
    .wr_no(wr_no), .done_o(done_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // mode: 0 READY off, 1 sync, 2 async
  function automatic int exp_len(input int mode, input int ws, input int d);
    if (mode == 0) return ws + 1;
    if (mode == 1) return max2(ws, d + 1) + 1;
    return max2(ws, d + 2) + 1;
  endfunction

  task automatic run_txn(input int mode, input int ws, input int d,
                         input bit mx, input bit tw, input bit wr);
    int  len, idx, t, bad_dir, bad_done, exp, tl;
    string tag;
    tag = (mode == 0) ? "R3" : (mode == 1) ? "R4" : "R5";
    wr_i = wr; mux_i = mx; trail_ws_i = tw; ws_i = WS_W'(ws);
    rdy_en_i = (mode != 0); rdy_async_i = (mode == 2); req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(wr ? !wr_no : !rd_no, "R2", wr ? int'(wr_no) : int'(rd_no), 0);
    // R8: scramble command fields once the cycle runs
    wr_i = ~wr; mux_i = ~mx; trail_ws_i = ~tw; ws_i = ~WS_W'(ws);
    rdy_en_i = (mode == 0); rdy_async_i = (mode != 2);
    len = 0; idx = 0; bad_dir = 0; bad_done = 0;
    while ((wr ? !wr_no : !rd_no) && idx < 64) begin
      len++;
      if (wr ? !rd_no : !wr_no) bad_dir++;
      if (done_o) bad_done++;
      if (mode != 0 && idx == d) ready_ni = 1'b0;
      @(negedge clk_i);
      idx++;
    end
    exp = exp_len(mode, ws, d);
    check(len == exp, tag, len, exp);
    check(bad_dir == 0, "R8", bad_dir, 0);
    check(bad_done == 0 && done_o, "R6", int'(done_o), 1);
    ready_ni = 1'b1;
    tl = int'(mx) + int'(tw);
    t = 0;
    while (busy_o && t < 8) begin
      @(negedge clk_i);
      t++;
    end
    check(t == tl, "R7", t, tl);
    if (t > 0) check(!done_o, "R6", int'(done_o), 0);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_b2b(input bit mx, input bit tw);
    int gap, exp;
    wr_i = 1'b0; mux_i = mx; trail_ws_i = tw; ws_i = '0;
    rdy_en_i = 1'b0; rdy_async_i = 1'b0; req_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    gap = 0;
    while (rd_no && gap < 16) begin
      gap++;
      @(negedge clk_i);
    end
    exp = int'(mx) + int'(tw) + 1;
    check(gap == exp, "R7", gap, exp);
    req_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(rd_no && wr_no, "R1", int'({rd_no, wr_no}), 3);
    check(!done_o && !busy_o, "R1", int'({done_o, busy_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(rd_no && wr_no && !busy_o && !done_o, "R1",
          int'({rd_no, wr_no, busy_o, done_o}), 12);

    // R3 with READY held inactive throughout; R4/R5 sweep the READY cycle
    for (int mode = 0; mode < 3; mode++)
      for (int ws = 0; ws < 4; ws++)
        for (int d = 0; d < ((mode == 0) ? 1 : 5); d++)
          for (int mt = 0; mt < 4; mt++)
            run_txn(mode, ws, d, mt[1], mt[0], ((ws + d + mt) % 2) == 1);

    for (int mt = 0; mt < 4; mt++) run_b2b(mt[1], mt[0]);

    // R8: request during busy is held off until the trailing delay ends
    wr_i = 1'b1; mux_i = 1'b1; trail_ws_i = 1'b1; ws_i = 4'd1;
    rdy_en_i = 1'b0; rdy_async_i = 1'b0; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b1;
    @(negedge clk_i);
    check(done_o && wr_no, "R8", int'(wr_no), 1);
    repeat (2) @(negedge clk_i);
    check(!busy_o && wr_no, "R8", int'(busy_o), 0);
    @(negedge clk_i);
    check(!wr_no, "R8", int'(wr_no), 0);
    req_i = 1'b0;
    repeat (8) @(negedge clk_i);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule